// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry Out

This block is a purely combinational shifter that sits in front of the second ALU operand. It takes a 32-bit operand, a shift kind, a shift count and the current carry flag. It returns the shifted operand and a shifter carry that the flag logic downstream may capture. There are five shift kinds: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right that goes through the carry flag. There is no arithmetic left shift, because the logical left shift already does that job.

The shift count comes from one of two places. The first is a 5-bit field carried in the instruction. The second is the low byte of a register, which the caller passes in already cut to 8 bits. A count of zero leaves both the operand and the carry unchanged. Register counts of 32 or more follow fixed saturation rules, so the carry always equals the last bit that left the word.

Top module: `operand_shifter`

## Requirements
- R1: `cnt_sel`=1 takes the count from `cnt_reg` (8 bits, 0 to 255). `cnt_sel`=0 takes it from `cnt_imm` (5 bits, 0 to 31).
- R2: For kinds 0 to 3, a count of zero gives `res`=`opnd` and `c_out`=`c_in`.
- R3: Kind 0 (logical left) with count n in 1..31 gives `opnd` shifted up by n with zeros filled in, and `c_out`=`opnd[32-n]`.
- R4: Kind 1 (logical right) with count n in 1..31 gives `opnd` shifted down by n with zeros filled in, and `c_out`=`opnd[n-1]`.
- R5: Kind 2 (arithmetic right) with count n in 1..31 copies `opnd[31]` into the vacated top bits, and `c_out`=`opnd[n-1]`.
- R6: For kinds 0 and 1 with a count of exactly 32, `res`=0 and `c_out` is `opnd[0]` for kind 0 or `opnd[31]` for kind 1. With a count above 32, `res`=0 and `c_out`=0.
- R7: Kind 2 with a count of 32 or more sets every bit of `res` to `opnd[31]`, and `c_out`=`opnd[31]`.
- R8: Kind 3 (rotate right) rotates by the low 5 bits of the count, and `c_out`=`res[31]`. A nonzero count that is a multiple of 32 returns `opnd` unchanged with `c_out`=`opnd[31]`.
- R9: Kind 4 ignores the count. It gives `res`={`c_in`, `opnd[31:1]`} and `c_out`=`opnd[0]`.
- R10: Kind codes 5, 6 and 7 pass `opnd` through unchanged with `c_out`=`c_in`, whatever the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd | input | 32 | Operand to shift |
| kind | input | 3 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry |
| cnt_sel | input | 1 | 1 selects the register count, 0 selects the immediate count |
| cnt_imm | input | 5 | Immediate shift count |
| cnt_reg | input | 8 | Low byte of the count register |
| c_in | input | 1 | Current carry flag |
| res | output | 32 | Shifted operand |
| c_out | output | 1 | Shifter carry out |

## Verification
The block holds no state, so any fault in its internal paths shows on `res` or `c_out` within the same evaluation, for the input that exposes it. The faults most likely to survive are at the edges of the count range: a saturation limit that is off by one at 32 or 33, a carry index that is one bit off, a left shift with its bits reversed the wrong way, or a sign fill that is missing. The bench steps through those counts for every kind. It also compares thousands of random vectors against a reference model that shifts one bit at a time.

// File: rtl/operand_shifter.sv
module operand_shifter #(
  parameter int W     = 32,
  parameter int IMM_W = 5,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]     opnd,
  input  logic [2:0]       kind,
  input  logic             cnt_sel,
  input  logic [IMM_W-1:0] cnt_imm,
  input  logic [CNT_W-1:0] cnt_reg,
  input  logic             c_in,
  output logic [W-1:0]     res,
  output logic             c_out
);
  localparam int RW = $clog2(W);
  localparam int EW = 2*W + 2;
  localparam logic [CNT_W-1:0] SAT = CNT_W'(W + 1);
  localparam logic [2:0] K_LSL = 3'd0;
  localparam logic [2:0] K_LSR = 3'd1;
  localparam logic [2:0] K_ASR = 3'd2;
  localparam logic [2:0] K_ROR = 3'd3;
  localparam logic [2:0] K_RRX = 3'd4;

  logic [CNT_W-1:0] cnt, cnt_sat;
  logic [W-1:0]     opnd_rev, src, sh_res, sh_rev, rot;
  logic [EW-1:0]    ext;
  logic [W:0]       sh;
  logic             fill;
  logic [W-1:0]     stage [RW+1];

  assign cnt     = cnt_sel ? cnt_reg : CNT_W'(cnt_imm);
  assign cnt_sat = (cnt > SAT) ? SAT : cnt;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign opnd_rev[i] = opnd[W-1-i];
    assign sh_rev[i]   = sh_res[W-1-i];
  end

  assign src    = (kind == K_LSL) ? opnd_rev : opnd;
  assign fill   = (kind == K_ASR) & opnd[W-1];
  assign ext    = {{(W+1){fill}}, src, 1'b0};
  assign sh     = (W+1)'(ext >> cnt_sat);
  assign sh_res = sh[W:1];

  assign stage[0] = opnd;
  for (genvar s = 0; s < RW; s++) begin : g_rot
    localparam int D = 1 << s;
    assign stage[s+1] = cnt[s] ? {stage[s][D-1:0], stage[s][W-1:D]} : stage[s];
  end
  assign rot = stage[RW];

  always_comb begin
    res   = opnd;
    c_out = c_in;
    if (kind == K_RRX) begin
      res   = {c_in, opnd[W-1:1]};
      c_out = opnd[0];
    end else if (cnt != '0) begin
      case (kind)
        K_LSL:        begin res = sh_rev; c_out = sh[0]; end
        K_LSR, K_ASR: begin res = sh_res; c_out = sh[0]; end
        K_ROR:        begin res = rot;    c_out = rot[W-1]; end
        default:      ;
      endcase
    end
  end

  always_comb begin
    a_r2_zero_count: assert (!(cnt == '0 && kind <= K_ROR) || (res == opnd && c_out == c_in))
      else $error("R2 zero count altered data or carry");
    a_r5_sign_kept: assert (kind != K_ASR || res[W-1] == opnd[W-1])
      else $error("R5 arithmetic shift lost sign");
    a_r6_far_zero: assert (!((kind == K_LSL || kind == K_LSR) && cnt > CNT_W'(W)) || (res == '0 && !c_out))
      else $error("R6 long logical shift not zero");
    a_r8_rot_ones: assert (kind != K_ROR || $countones(res) == $countones(opnd))
      else $error("R8 rotate changed population");
    a_r9_rrx_carry: assert (kind != K_RRX || (c_out == opnd[0] && res[W-1] == c_in))
      else $error("R9 rotate through carry wrong");
    a_r10_spare: assert (kind <= K_RRX || (res == opnd && c_out == c_in))
      else $error("R10 spare code not pass-through");
  end
endmodule

// File: tb/operand_shifter_tb.sv
module operand_shifter_tb;
  logic        clk = 0;
  logic [31:0] opnd = '0;
  logic [2:0]  kind = '0;
  logic        cnt_sel = 0;
  logic [4:0]  cnt_imm = '0;
  logic [7:0]  cnt_reg = '0;
  logic        c_in = 0;
  logic [31:0] res;
  logic        c_out;
  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  operand_shifter u_dut (.opnd(opnd), .kind(kind), .cnt_sel(cnt_sel), .cnt_imm(cnt_imm),
                         .cnt_reg(cnt_reg), .c_in(c_in), .res(res), .c_out(c_out));

  function automatic void model(input logic [31:0] v_in, input logic [2:0] k, input int n,
                                input logic ci, output logic [31:0] v, output logic c);
    v = v_in; c = ci;
    case (k)
      3'd0: for (int i = 0; i < n; i++) begin c = v[31]; v = v << 1; end
      3'd1: for (int i = 0; i < n; i++) begin c = v[0]; v = v >> 1; end
      3'd2: for (int i = 0; i < n; i++) begin c = v[0]; v = {v[31], v[31:1]}; end
      3'd3: if (n != 0) begin
              if (n % 32 == 0) c = v[31];
              for (int i = 0; i < n % 32; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
            end
      3'd4: begin c = v[0]; v = {ci, v[31:1]}; end
      default: ;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] k, input int n);
    if (k > 3'd4) return "R10";
    if (k == 3'd4) return "R9";
    if (n == 0) return "R2";
    if (k == 3'd3) return "R8";
    if (k == 3'd2) return (n >= 32) ? "R7" : "R5";
    if (n >= 32) return "R6";
    return (k == 3'd0) ? "R3" : "R4";
  endfunction

  task automatic apply(input logic [31:0] v, input logic [2:0] k, input logic sel,
                       input logic [4:0] ci5, input logic [7:0] cr8, input logic ci);
    logic [31:0] ev; logic ec; int n; string t;
    @(posedge clk); #1;
    opnd = v; kind = k; cnt_sel = sel; cnt_imm = ci5; cnt_reg = cr8; c_in = ci;
    n = sel ? int'(cr8) : int'(ci5);
    model(v, k, n, ci, ev, ec);
    t = sel ? {tag(k, n), "/R1"} : tag(k, n);
    @(negedge clk);
    compared++;
    if (res !== ev || c_out !== ec) begin
      mismatched++;
      $display("FAIL %s kind=%0d n=%0d opnd=%h cin=%b: got %h/%b expected %h/%b",
               t, k, n, v, ci, res, c_out, ev, ec);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hA5C3_0F69; pats[3] = 32'hFFFF_FFFF;
    // reset-like idle state: all inputs zero give zero output (R2)
    @(negedge clk);
    compared++;
    if (res !== '0 || c_out !== 1'b0) begin
      mismatched++;
      $display("FAIL R2 idle: got %h/%b expected 0/0", res, c_out);
    end
    // R1 immediate against register source, R2..R8 count sweep at edges
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 8; k++)
        for (int c = 0; c < 2; c++) begin
          foreach (pats[j]) if (j == 0) begin end
          apply(pats[p], 3'(k), 1'b0, 5'd0, 8'd200, c[0]);
          apply(pats[p], 3'(k), 1'b0, 5'd1, 8'd0, c[0]);
          apply(pats[p], 3'(k), 1'b0, 5'd31, 8'd0, c[0]);
          apply(pats[p], 3'(k), 1'b1, 5'd7, 8'd0, c[0]);
          apply(pats[p], 3'(k), 1'b1, 5'd0, 8'd1, c[0]);
          apply(pats[p], 3'(k), 1'b1, 5'd3, 8'd31, c[0]);
          apply(pats[p], 3'(k), 1'b1, 5'd3, 8'd32, c[0]);
          apply(pats[p], 3'(k), 1'b1, 5'd3, 8'd33, c[0]);
          apply(pats[p], 3'(k), 1'b1, 5'd3, 8'd64, c[0]);
          apply(pats[p], 3'(k), 1'b1, 5'd3, 8'd255, c[0]);
        end
    // random sweep over every kind, R1 to R10
    for (int r = 0; r < 4000; r++) begin
      logic [7:0] cr;
      case ($urandom % 6)
        0: cr = 8'd0;
        1: cr = 8'd32;
        2: cr = 8'd33;
        3: cr = 8'($urandom % 32);
        4: cr = 8'(32 * ($urandom % 8));
        default: cr = 8'($urandom);
      endcase
      apply($urandom, 3'($urandom % 8), 1'($urandom), 5'($urandom), cr, 1'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule